// File: doc/BRIEF.md
# TDM Codec Serial Port Master

This block is the master end of a time-division-multiplexed serial link to an audio codec. It divides the system clock down to a bit clock and marks each frame with a one-bit-wide frame sync pulse. It shifts fixed-length words out on a serial data line and in from a second one, most significant bit first. A frame is a run of equal-length slots. Two slot masks choose which slots carry transmit data and which carry receive data. In slots where the master does not transmit, the data output is released to high impedance.

Words are exchanged with the host through a small bank of buffer registers. The host writes transmit words into the bank and reads received words from it. One buffer index is shared by both directions. It steps at the end of every slot that is enabled in either mask and wraps after a configured number of words. A one-cycle interrupt pulse marks each wrap, so the host refills the transmit registers and collects received words once per buffer pass. If the host does not refill in time, the old transmit words are sent again.

All framing values are configuration inputs: bit-clock divider, word length, slots per frame, buffer length, the two masks and a global enable. When the enable is low, the serial side parks idle. When the enable rises again, a new frame sequence begins with a lead-in bit period.

Top module: `tdm_codec_master`

## Requirements
- R1: While `rst` is high or `cfg_enable` is low, `sck`, `fsync`, `sdo`, `sdo_oe` and `irq` are all low, and `sck` does not toggle.
- R2: After `cfg_enable` rises, `sck` starts low and toggles once every `cfg_half_div`+1 system clocks. A full bit period is therefore 2×(`cfg_half_div`+1) clocks.
- R3: A bit period runs from one rising `sck` edge to the next. A frame holds (`cfg_slot_last`+1) slots of (`cfg_word_last`+1) bits each. `fsync` is high exactly in the final bit period of every frame.
- R4: The first bit period after enable is a lead-in: `fsync` is high and no data is driven. Slot 0 of the first frame begins at the following rising edge, one bit clock after the sync.
- R5: In a slot whose bit is set in `cfg_tx_slots` (bit n = slot n), `sdo` carries bits `cfg_word_last` down to 0 of the loaded transmit word, most significant first. The value changes only together with a rising `sck` edge.
- R6: `sdo_oe` is high for every bit of transmit-enabled slots. It is low for all bits of other slots and for the lead-in.
- R7: `sdi` is sampled just before each falling `sck` edge. In a slot whose bit is set in `cfg_rx_slots`, the word is stored at the current buffer index once its last bit is sampled. The word is right-justified, with bits above the word length zero.
- R8: The buffer index starts at 0 on enable. It advances at the end of each slot enabled in either mask and wraps to 0 after the entry numbered `cfg_buf_last`. Each transmit-enabled slot loads its word from the transmit register at the index in effect when the slot starts.
- R9: `irq` pulses high for exactly one system clock each time the buffer index wraps.
- R10: A write with `host_we` high stores `host_wdata` into transmit register `host_addr`. `host_rdata` shows receive register `host_addr` with no delay.
- R11: Dropping and raising `cfg_enable` restarts the sequence from the lead-in, with the buffer index back at 0. Buffer contents are kept.
- R12: A slot with its receive mask bit clear writes no receive register, even when the index advances through it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Global enable; low parks the serial side |
| cfg_half_div | input | DIV_W | System clocks per half bit period, minus one |
| cfg_word_last | input | BIT_W | Bits per word minus one |
| cfg_slot_last | input | SLOT_W | Slots per frame minus one |
| cfg_buf_last | input | IDX_W | Words per buffer pass minus one |
| cfg_tx_slots | input | SLOTS | Transmit slot mask, bit n = slot n |
| cfg_rx_slots | input | SLOTS | Receive slot mask, bit n = slot n |
| host_we | input | 1 | Transmit register write strobe |
| host_addr | input | IDX_W | Register index for write and read |
| host_wdata | input | WORD_W | Transmit word to store |
| host_rdata | output | WORD_W | Receive register at `host_addr` |
| sdi | input | 1 | Serial data from the codec |
| sck | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync pulse |
| sdo | output | 1 | Serial data to the codec |
| sdo_oe | output | 1 | Output enable for `sdo`; low means high impedance |
| irq | output | 1 | One-clock buffer-wrap interrupt |

## Verification
The bench uses the default build: 16-bit words, up to 8 slots, a 4-entry buffer and an 8-bit divider. Within that build, each run sets its own configuration. The runs cover half-period divisors of 1, 2 and 3 clocks, word lengths of 16, 8 and 4 bits, frames of 8, 4 and 2 slots, and buffer passes of 2, 3 and 1 words. Sparse and overlapping masks exercise slots that only transmit, only receive, or both, so shared-index stepping through non-receiving slots and an interrupt on every active slot are both reached. A disable in the middle of a frame, after the index has moved, shows the restart behaviour.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

    // Bit-clock event seen in the current system cycle
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_RISE = 2'd1,
        EV_FALL = 2'd2
    } sck_ev_t;

    // Mask with bits [last_bit:0] set
    function automatic logic [31:0] low_mask(input logic [31:0] last_bit);
        logic [32:0] wide;
        wide = (33'd1 << (last_bit + 32'd1)) - 33'd1;
        return wide[31:0];
    endfunction

endpackage

// File: rtl/tdm_clkgen.sv
module tdm_clkgen
    import tdm_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] half_div,
    output logic             sck,
    output sck_ev_t          ev
);

    logic [DIV_W-1:0] cnt;
    logic             tick;

    assign tick = en && (cnt >= half_div);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
            sck <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            sck <= ~sck;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        if (!tick)    ev = EV_NONE;
        else if (sck) ev = EV_FALL;
        else          ev = EV_RISE;
    end

    a_r1_sck_parks_low: assert property (@(posedge clk) disable iff (rst)
        !en |=> !sck);

    a_r2_sck_holds_between_ticks: assert property (@(posedge clk) disable iff (rst)
        (en && !tick) |=> $stable(sck));

endmodule

// File: rtl/tdm_framer.sv
module tdm_framer
    import tdm_pkg::*;
#(
    parameter int BIT_W  = 4,
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  sck_ev_t           ev,
    input  logic [BIT_W-1:0]  word_last,
    input  logic [SLOT_W-1:0] slot_last,
    output logic [SLOT_W-1:0] slot,
    output logic [BIT_W-1:0]  bitn,
    output logic [SLOT_W-1:0] nxt_slot,
    output logic [BIT_W-1:0]  nxt_bit,
    output logic              step,
    output logic              lead,
    output logic              live,
    output logic              fsync
);

    logic started;
    logic prime;
    logic word_done;

    always_comb begin
        word_done = (bitn == '0);
        nxt_bit   = word_done ? word_last : bitn - 1'b1;
        if (!word_done)              nxt_slot = slot;
        else if (slot >= slot_last)  nxt_slot = '0;
        else                         nxt_slot = slot + 1'b1;
    end

    assign step = (ev == EV_RISE) && started;
    assign lead = (ev == EV_RISE) && !started;
    assign live = started && !prime;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            started <= 1'b0;
            prime   <= 1'b0;
            slot    <= '0;
            bitn    <= '0;
            fsync   <= 1'b0;
        end else if (lead) begin
            started <= 1'b1;
            prime   <= 1'b1;
            slot    <= slot_last;
            bitn    <= '0;
            fsync   <= 1'b1;
        end else if (step) begin
            prime   <= 1'b0;
            slot    <= nxt_slot;
            bitn    <= nxt_bit;
            fsync   <= (nxt_slot == slot_last) && (nxt_bit == '0);
        end
    end

    a_r4_fsync_only_when_running: assert property (@(posedge clk) disable iff (rst)
        fsync |-> started);

    a_r3_position_holds_between_rises: assert property (@(posedge clk) disable iff (rst)
        (en && ev != EV_RISE) |=> ($stable(bitn) && $stable(slot)));

endmodule

// File: rtl/tdm_txlane.sv
module tdm_txlane #(
    parameter int WORD_W = 16,
    parameter int BIT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              step,
    input  logic              lead,
    input  logic [BIT_W-1:0]  nxt_bit,
    input  logic [BIT_W-1:0]  word_last,
    input  logic              slot_tx_on,
    input  logic [WORD_W-1:0] fresh_word,
    output logic              sdo,
    output logic              sdo_oe
);

    logic [WORD_W-1:0] held;
    logic              slot_start;

    assign slot_start = (nxt_bit == word_last);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            held   <= '0;
            sdo    <= 1'b0;
            sdo_oe <= 1'b0;
        end else if (lead) begin
            sdo    <= 1'b0;
            sdo_oe <= 1'b0;
        end else if (step) begin
            sdo_oe <= slot_tx_on;
            if (slot_start) begin
                held <= fresh_word;
                sdo  <= slot_tx_on && fresh_word[nxt_bit];
            end else begin
                sdo  <= slot_tx_on && held[nxt_bit];
            end
        end
    end

    a_r6_oe_low_when_disabled: assert property (@(posedge clk) disable iff (rst)
        !en |=> !sdo_oe);

    a_r5_line_changes_on_rise: assert property (@(posedge clk) disable iff (rst)
        (en && !step && !lead) |=> ($stable(sdo) && $stable(sdo_oe)));

endmodule

// File: rtl/tdm_bufbank.sv
module tdm_bufbank
    import tdm_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 4,
    parameter int IDX_W  = 2,
    parameter int BIT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              sample,
    input  logic              word_end,
    input  logic              rx_on,
    input  logic              tx_on,
    input  logic              sdi,
    input  logic [BIT_W-1:0]  word_last,
    input  logic [IDX_W-1:0]  buf_last,
    input  logic              host_we,
    input  logic [IDX_W-1:0]  host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] tx_word,
    output logic [WORD_W-1:0] host_rdata,
    output logic              irq
);

    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  eff_last;
    logic [WORD_W-1:0] rx_sh;
    logic [WORD_W-1:0] shifted;
    logic [WORD_W-1:0] captured;
    logic              rx_write;
    logic              slot_active;
    logic [WORD_W-1:0] tx_view [DEPTH];
    logic [WORD_W-1:0] rx_view [DEPTH];

    always_comb begin
        eff_last    = (buf_last > IDX_W'(DEPTH - 1)) ? IDX_W'(DEPTH - 1) : buf_last;
        shifted     = {rx_sh[WORD_W-2:0], sdi};
        captured    = shifted & WORD_W'(low_mask(32'(word_last)));
        rx_write    = sample && word_end && rx_on;
        slot_active = rx_on || tx_on;
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_entry
            logic [WORD_W-1:0] tx_q;
            logic [WORD_W-1:0] rx_q;

            always_ff @(posedge clk) begin
                if (rst)
                    tx_q <= '0;
                else if (host_we && host_addr == IDX_W'(g))
                    tx_q <= host_wdata;
            end

            always_ff @(posedge clk) begin
                if (rst)
                    rx_q <= '0;
                else if (rx_write && idx == IDX_W'(g))
                    rx_q <= captured;
            end

            assign tx_view[g] = tx_q;
            assign rx_view[g] = rx_q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            idx   <= '0;
            rx_sh <= '0;
            irq   <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (sample) begin
                if (rx_on)
                    rx_sh <= shifted;
                if (word_end && slot_active) begin
                    if (idx >= eff_last) begin
                        idx <= '0;
                        irq <= 1'b1;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
            end
        end
    end

    assign tx_word    = tx_view[idx];
    assign host_rdata = rx_view[host_addr];

    a_r9_irq_one_cycle: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    a_r8_irq_with_index_wrap: assert property (@(posedge clk) disable iff (rst)
        irq |-> (idx == '0));

endmodule

// File: rtl/tdm_codec_master.sv
module tdm_codec_master
    import tdm_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int WORD_W    = 16,
    parameter int SLOTS     = 8,
    parameter int BUF_DEPTH = 4,
    localparam int BIT_W    = $clog2(WORD_W),
    localparam int SLOT_W   = $clog2(SLOTS),
    localparam int IDX_W    = $clog2(BUF_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_enable,
    input  logic [DIV_W-1:0]  cfg_half_div,
    input  logic [BIT_W-1:0]  cfg_word_last,
    input  logic [SLOT_W-1:0] cfg_slot_last,
    input  logic [IDX_W-1:0]  cfg_buf_last,
    input  logic [SLOTS-1:0]  cfg_tx_slots,
    input  logic [SLOTS-1:0]  cfg_rx_slots,
    input  logic              host_we,
    input  logic [IDX_W-1:0]  host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    input  logic              sdi,
    output logic              sck,
    output logic              fsync,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              irq
);

    sck_ev_t           ev;
    logic [SLOT_W-1:0] slot;
    logic [SLOT_W-1:0] nxt_slot;
    logic [BIT_W-1:0]  bitn;
    logic [BIT_W-1:0]  nxt_bit;
    logic              step;
    logic              lead;
    logic              live;
    logic [WORD_W-1:0] tx_word;
    logic              sample;

    assign sample = (ev == EV_FALL) && live;

    tdm_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk      (clk),
        .rst      (rst),
        .en       (cfg_enable),
        .half_div (cfg_half_div),
        .sck      (sck),
        .ev       (ev)
    );

    tdm_framer #(.BIT_W(BIT_W), .SLOT_W(SLOT_W)) u_framer (
        .clk       (clk),
        .rst       (rst),
        .en        (cfg_enable),
        .ev        (ev),
        .word_last (cfg_word_last),
        .slot_last (cfg_slot_last),
        .slot      (slot),
        .bitn      (bitn),
        .nxt_slot  (nxt_slot),
        .nxt_bit   (nxt_bit),
        .step      (step),
        .lead      (lead),
        .live      (live),
        .fsync     (fsync)
    );

    tdm_txlane #(.WORD_W(WORD_W), .BIT_W(BIT_W)) u_txlane (
        .clk        (clk),
        .rst        (rst),
        .en         (cfg_enable),
        .step       (step),
        .lead       (lead),
        .nxt_bit    (nxt_bit),
        .word_last  (cfg_word_last),
        .slot_tx_on (cfg_tx_slots[nxt_slot]),
        .fresh_word (tx_word),
        .sdo        (sdo),
        .sdo_oe     (sdo_oe)
    );

    tdm_bufbank #(
        .WORD_W (WORD_W),
        .DEPTH  (BUF_DEPTH),
        .IDX_W  (IDX_W),
        .BIT_W  (BIT_W)
    ) u_bufbank (
        .clk        (clk),
        .rst        (rst),
        .en         (cfg_enable),
        .sample     (sample),
        .word_end   (bitn == '0),
        .rx_on      (cfg_rx_slots[slot]),
        .tx_on      (cfg_tx_slots[slot]),
        .sdi        (sdi),
        .word_last  (cfg_word_last),
        .buf_last   (cfg_buf_last),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .tx_word    (tx_word),
        .host_rdata (host_rdata),
        .irq        (irq)
    );

endmodule

// File: tb/tdm_codec_master_tb.sv
module tdm_codec_master_tb;

    localparam int CLK_PERIOD = 10;
    localparam int QTR        = CLK_PERIOD / 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_enable = 1'b0;
    logic [7:0]  cfg_half_div = '0;
    logic [3:0]  cfg_word_last = '0;
    logic [2:0]  cfg_slot_last = '0;
    logic [1:0]  cfg_buf_last = '0;
    logic [7:0]  cfg_tx_slots = '0;
    logic [7:0]  cfg_rx_slots = '0;
    logic        host_we = 1'b0;
    logic [1:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        sdi = 1'b0;
    logic        sck, fsync, sdo, sdo_oe, irq;

    int checks = 0;
    int errors = 0;

    // reference model state
    int          k, cyc_since, DIV, WL, S, F, BL, idx_m, exp_irq, got_irq, irq_hi;
    logic [7:0]  txm, rxm;
    logic [15:0] txb [4];
    logic [15:0] rxexp [4];
    logic [15:0] curw;
    logic        mon_on = 1'b0;
    logic        prev_sck = 1'b0;
    logic        prev_irq = 1'b0;

    tdm_codec_master u_dut (
        .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_half_div(cfg_half_div),
        .cfg_word_last(cfg_word_last), .cfg_slot_last(cfg_slot_last),
        .cfg_buf_last(cfg_buf_last), .cfg_tx_slots(cfg_tx_slots),
        .cfg_rx_slots(cfg_rx_slots), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .sdi(sdi), .sck(sck),
        .fsync(fsync), .sdo(sdo), .sdo_oe(sdo_oe), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] cw(input int fr, input int s, input int wl);
        logic [31:0] v;
        v = 32'h5A00 ^ (fr * 32'h131) ^ (s * 32'h1111);
        return v[15:0] & 16'((32'd1 << wl) - 32'd1);
    endfunction

    task automatic on_rise(input int kk);
        int fp, fr, sl, bi, ps, pf;
        logic eo;
        logic [15:0] cword;
        if (kk == 0) begin
            chk("R2 lead-in delay", cyc_since, DIV + 2);
            chk("R4 lead-in fsync", fsync, 1);
            chk("R6 lead-in oe", sdo_oe, 0);
            sdi = 1'b0;
            return;
        end
        chk("R2 bit period", cyc_since, 2 * (DIV + 1));
        fp = (kk - 1) % F;
        fr = (kk - 1) / F;
        sl = fp / WL;
        bi = WL - 1 - (fp % WL);
        if ((fp % WL) == 0 && kk > 1) begin
            ps = (sl == 0) ? S - 1 : sl - 1;
            pf = (sl == 0) ? fr - 1 : fr;
            if (rxm[ps]) rxexp[idx_m] = cw(pf, ps, WL);
            if (txm[ps] || rxm[ps]) begin
                if (idx_m == BL - 1) begin
                    idx_m = 0;
                    exp_irq++;
                end else begin
                    idx_m++;
                end
            end
        end
        if ((fp % WL) == 0) curw = txb[idx_m];
        chk("R3 fsync position", fsync, (fp == F - 1) ? 1 : 0);
        eo = txm[sl];
        chk("R6 output enable", sdo_oe, eo);
        if (eo) chk("R5/R8 serial bit", sdo, curw[bi]);
        cword = cw(fr, sl, WL);
        sdi = cword[bi];
    endtask

    always @(negedge clk) begin
        if (mon_on) begin
            cyc_since++;
            if (irq) irq_hi++;
            if (irq && !prev_irq) got_irq++;
            if (sck && !prev_sck) begin
                on_rise(k);
                cyc_since = 0;
                k++;
            end
        end
        prev_sck = sck;
        prev_irq = irq;
    end

    task automatic tick_drive();
        @(posedge clk);
        #(QTR);
    endtask

    task automatic host_write(input int a, input logic [15:0] d);
        tick_drive();
        host_we    = 1'b1;
        host_addr  = 2'(a);
        host_wdata = d;
        tick_drive();
        host_we    = 1'b0;
    endtask

    task automatic run_cfg(input int div, input int wl, input int s, input int bl,
                           input logic [7:0] tm, input logic [7:0] rm, input int target);
        DIV = div; WL = wl; S = s; F = s * wl; BL = bl; txm = tm; rxm = rm;
        cfg_half_div  = 8'(div);
        cfg_word_last = 4'(wl - 1);
        cfg_slot_last = 3'(s - 1);
        cfg_buf_last  = 2'(bl - 1);
        cfg_tx_slots  = tm;
        cfg_rx_slots  = rm;
        idx_m = 0; exp_irq = 0; got_irq = 0; irq_hi = 0; k = 0; cyc_since = 0;
        tick_drive();
        cfg_enable = 1'b1;
        mon_on     = 1'b1;
        while (k < target) tick_drive();
        cfg_enable = 1'b0;
        mon_on     = 1'b0;
    endtask

    task automatic check_idle(input string tag);
        logic moved = 1'b0;
        tick_drive();
        tick_drive();
        for (int i = 0; i < 12; i++) begin
            if (sck || fsync || sdo || sdo_oe || irq) moved = 1'b1;
            tick_drive();
        end
        chk(tag, moved, 0);
    endtask

    task automatic check_rx(input string tag_written, input string tag_kept);
        for (int i = 0; i < 4; i++) begin
            host_addr = 2'(i);
            #1;
            chk((rxexp[i] == 16'h0) ? tag_kept : tag_written, host_rdata, rxexp[i]);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) tick_drive();
        chk("R1 reset sck", sck, 0);
        chk("R1 reset fsync/oe/irq", {fsync, sdo_oe, irq, sdo}, 0);
        rst = 1'b0;
        tick_drive();
        host_addr = 2'd2;
        #1;
        chk("R10 reset rx register", host_rdata, 0);
        for (int i = 0; i < 4; i++) rxexp[i] = 16'h0;
        for (int i = 0; i < 4; i++) begin
            txb[i] = 16'hC3A5 ^ 16'(i * 32'h1248);
            host_write(i, txb[i]);
        end
        check_idle("R1 idle while disabled");
    endtask

    // Partial run stopped after slot 0 finished, index already at 1
    task automatic t_disable_midframe();
        run_cfg(1, 16, 8, 2, 8'h01, 8'h01, 18);
        check_idle("R1 idle after mid-frame disable");
        chk("R9 no wrap in partial run", got_irq, 0);
    endtask

    task automatic t_default();
        run_cfg(1, 16, 8, 2, 8'h01, 8'h01, 2 * 128 + 2);
        chk("R9 irq count default", got_irq, exp_irq);
        chk("R9 irq width default", irq_hi, got_irq);
        chk("R11 restart index from zero", exp_irq, 1);
        check_rx("R7 R10 rx default", "R12 rx untouched default");
    endtask

    task automatic t_multi();
        run_cfg(2, 8, 4, 3, 8'h0A, 8'h06, 2 * 32 + 2);
        chk("R9 irq count multi", got_irq, exp_irq);
        chk("R8 wraps with three active slots", exp_irq, 2);
        chk("R9 irq width multi", irq_hi, got_irq);
        check_rx("R7 rx multi", "R12 rx skipped slot");
        host_addr = 2'd2;
        #1;
        chk("R12 tx-only slot wrote nothing", host_rdata, rxexp[2]);
    endtask

    task automatic t_short();
        run_cfg(0, 4, 2, 1, 8'h03, 8'h01, 2 * 8 + 2);
        chk("R9 irq every active slot", got_irq, 4);
        chk("R9 irq width short", irq_hi, got_irq);
        check_rx("R7 rx short word right-justified", "R12 rx short untouched");
        check_idle("R1 idle at end");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL R2 watchdog: actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_disable_midframe();
        t_default();
        t_multi();
        t_short();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule